// File: doc/BRIEF.md
# ECC-Protected Word RAM with Fault Injection

This block is a single-port RAM of 32-bit words. Each word is guarded by three 7-bit SECDED check codes. One code covers the lower 16 data bits, one covers the upper 16 data bits, and one is computed from the word address. A CPU-style port issues reads and writes with byte enables. A two-bit mode input decides whether an access reaches the corrected data path, the raw data bits, or the stored check bits. All three views share one address space.

Normal reads check each half on its own. A single-bit fault in a half is repaired before the data is returned. A double-bit fault is reported, and so is any mismatch in the address code. The two test modes let software write data without touching the check bits, or rewrite the check bits directly. This lets software plant known faults and confirm at run time that detection and correction still work.

Every accepted access is classified into one of six states. The state register holds the class of the previous cycle's access:

- `ST_IDLE`: no access.
- `ST_WRITE`: any accepted write.
- `ST_NREAD`: a normal read.
- `ST_DREAD`: a data-test read.
- `ST_CREAD`: a check-test read.
- `ST_REJECT`: a refused access.

From any state, the next state depends only on the current inputs. The transitions are:

- No strobe goes to `ST_IDLE`.
- Both strobes together go to `ST_REJECT`.
- A reserved mode goes to `ST_REJECT`.
- A test-mode access without all four byte enables goes to `ST_REJECT`.
- A write otherwise goes to `ST_WRITE`.
- A read otherwise goes to the read state of its mode.

Top module: `ecc_ram`

## Requirements
- R1: A normal-mode write (`mode`=00) stores the data and all three codes. A normal read returns the word on `rdata` with `rvalid` high in the cycle after the strobe, with no error pulse, whatever the byte enables of the read. Bit i of a code is the XOR of the input bits j whose column has bit i set. Column j is the j-th smallest 7-bit value with exactly three ones. The address code is computed over the word address zero-extended to 16 bits.
- R2: On a normal read, a single-bit fault in one half, in a data bit or a check bit, is corrected in `rdata`, and `err_corr` pulses with `rvalid`.
- R3: On a normal read, a double-bit fault in a half pulses `err_uncorr`, and that half is returned unmodified.
- R4: On a normal read, any mismatch in the address code pulses both `err_addr` and `err_uncorr`. The data is still returned corrected.
- R5: In data-test mode (`mode`=01), a write changes only the data bits and leaves the stored codes intact. A read returns the raw stored data with no error pulse.
- R6: A check-test read (`mode`=10) returns the low-half code in bits 6:0, the high-half code in bits 14:8 and the address code in bits 22:16. Bits 7, 15 and 31:23 read as zero.
- R7: A check-test write stores bits 6:0, 14:8 and 22:16 as the three codes and leaves the data unchanged. Values in bits 7, 15 and 31:23 have no effect.
- R8: In either test mode, an access with `be` other than 1111 raises `acc_err` for one cycle after the strobe. It produces no `rvalid` and changes no storage.
- R9: Mode 11 is reserved, and any access in it is rejected as in R8. A cycle with both `rd_en` and `wr_en` high is rejected in the same way in every mode.
- R10: A normal write with partial byte enables merges the enabled bytes into the stored word after correction of that word. It then recomputes both half codes from the merged word.
- R11: During and right after reset, `rvalid`, `err_corr`, `err_uncorr`, `err_addr` and `acc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| mode | input | 2 | 00 normal, 01 data-test, 10 check-test, 11 reserved |
| addr | input | ADDR_W | Word address |
| be | input | 4 | Byte enables, bit k for data byte k |
| wdata | input | 32 | Write data or packed check codes |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read result present |
| err_corr | output | 1 | Correctable fault seen on a normal read |
| err_uncorr | output | 1 | Uncorrectable fault seen on a normal read |
| err_addr | output | 1 | Address code mismatch on a normal read |
| acc_err | output | 1 | Access refused |

## Verification
On one normal read, repair of one half and detection of a double fault in the other half can happen in the same cycle. The bench provokes this with a single data-test write that flips one bit in the low half and two bits in the high half. It then expects `err_corr` and `err_uncorr` together, with `rdata` holding the repaired low half next to the untouched faulty high half. A second overlap occurs when a partial normal write lands on a word that carries a planted single-bit fault. Correction and byte merging then happen in one access. This is judged by a later normal read that returns the merged, repaired word with no error pulse.

// File: rtl/ecc_ram_pkg.sv
`timescale 1ns/1ps
package ecc_ram_pkg;

    localparam int HALF_W = 16;
    localparam int CODE_W = 7;
    localparam int WORD_W = 2 * HALF_W;
    localparam int BYTES  = WORD_W / 8;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_DTEST  = 2'b01,
        MODE_CTEST  = 2'b10,
        MODE_RSVD   = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_NREAD,
        ST_DREAD,
        ST_CREAD,
        ST_REJECT
    } state_e;

    typedef struct packed {
        logic [CODE_W-1:0] acode;
        logic [CODE_W-1:0] hcode;
        logic [CODE_W-1:0] lcode;
    } chk_t;

    // Column j of the parity-check matrix: the j-th 7-bit value of weight three.
    function automatic logic [CODE_W-1:0] hsiao_col(input int j);
        int                n;
        logic [CODE_W-1:0] r;
        n = 0;
        r = '0;
        for (int v = 0; v < (1 << CODE_W); v++) begin
            if ($countones(v[CODE_W-1:0]) == 3) begin
                if (n == j) r = v[CODE_W-1:0];
                n++;
            end
        end
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] hsiao_enc(input logic [HALF_W-1:0] d);
        logic [CODE_W-1:0] c;
        c = '0;
        for (int j = 0; j < HALF_W; j++) begin
            if (d[j]) c ^= hsiao_col(j);
        end
        return c;
    endfunction

    // Packed layout of the three codes as seen in check-test mode.
    function automatic logic [WORD_W-1:0] chk_pack(input chk_t c);
        return {9'b0, c.acode, 1'b0, c.hcode, 1'b0, c.lcode};
    endfunction

    function automatic chk_t chk_unpack(input logic [WORD_W-1:0] w);
        chk_t c;
        c.lcode = w[6:0];
        c.hcode = w[14:8];
        c.acode = w[22:16];
        return c;
    endfunction

endpackage

// File: rtl/ecc_ram_enc.sv
`timescale 1ns/1ps
module ecc_ram_enc
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] addr,
    output chk_t              code
);
    localparam int HALVES = WORD_W / HALF_W;

    logic [CODE_W-1:0] half_code [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_code[h] = hsiao_enc(word[h*HALF_W +: HALF_W]);
    end

    assign code.lcode = half_code[0];
    assign code.hcode = half_code[1];
    assign code.acode = hsiao_enc(HALF_W'(addr));

endmodule

// File: rtl/ecc_ram_dec.sv
`timescale 1ns/1ps
module ecc_ram_dec
    import ecc_ram_pkg::*;
(
    input  logic [HALF_W-1:0] data,
    input  logic [CODE_W-1:0] stored,
    output logic [HALF_W-1:0] fixed,
    output logic              corr,
    output logic              uncorr
);
    logic [CODE_W-1:0] syn;
    logic [HALF_W-1:0] hit;

    assign syn = stored ^ hsiao_enc(data);

    for (genvar j = 0; j < HALF_W; j++) begin : g_col
        assign hit[j] = (syn == hsiao_col(j));
    end

    // A miss on every column leaves the half unmodified.
    assign fixed = data ^ hit;

    always_comb begin
        corr   = 1'b0;
        uncorr = 1'b0;
        if (syn != '0) begin
            if ((|hit) || ($countones(syn) == 1)) corr = 1'b1;
            else                                   uncorr = 1'b1;
        end
    end

endmodule

// File: rtl/ecc_ram_store.sv
`timescale 1ns/1ps
module ecc_ram_store
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we_data,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              we_chk,
    input  chk_t              wr_chk,
    output logic [WORD_W-1:0] rd_data,
    output chk_t              rd_chk
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] data_mem [DEPTH];
    chk_t              chk_mem  [DEPTH];

    always_ff @(posedge clk) begin
        if (we_data) data_mem[addr] <= wr_data;
        if (we_chk)  chk_mem[addr]  <= wr_chk;
    end

    assign rd_data = data_mem[addr];
    assign rd_chk  = chk_mem[addr];

endmodule

// File: rtl/ecc_ram.sv
`timescale 1ns/1ps
module ecc_ram
    import ecc_ram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rvalid,
    output logic              err_corr,
    output logic              err_uncorr,
    output logic              err_addr,
    output logic              acc_err
);
    state_e            state_q, state_d;
    mode_e             mode_v;
    logic              full_be;

    logic [WORD_W-1:0] raw_word;
    chk_t              raw_chk;
    logic [WORD_W-1:0] fixed_word;
    logic              corr_lo, corr_hi, unc_lo, unc_hi;
    logic              addr_bad;
    chk_t              cur_code;

    logic [WORD_W-1:0] merged;
    chk_t              merged_code;
    logic              we_data, we_chk;
    logic [WORD_W-1:0] st_wdata;
    chk_t              st_wchk;

    logic [WORD_W-1:0] rdata_q;
    logic              corr_q, unc_q, aerr_q, acc_q;

    assign mode_v  = mode_e'(mode);
    assign full_be = (be == {BYTES{1'b1}});

    // ---------------------------------------------------------------- storage
    ecc_ram_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .addr    (addr),
        .we_data (we_data),
        .wr_data (st_wdata),
        .we_chk  (we_chk),
        .wr_chk  (st_wchk),
        .rd_data (raw_word),
        .rd_chk  (raw_chk)
    );

    // ---------------------------------------------------------------- check path
    ecc_ram_dec u_dec_lo (
        .data   (raw_word[HALF_W-1:0]),
        .stored (raw_chk.lcode),
        .fixed  (fixed_word[HALF_W-1:0]),
        .corr   (corr_lo),
        .uncorr (unc_lo)
    );

    ecc_ram_dec u_dec_hi (
        .data   (raw_word[WORD_W-1:HALF_W]),
        .stored (raw_chk.hcode),
        .fixed  (fixed_word[WORD_W-1:HALF_W]),
        .corr   (corr_hi),
        .uncorr (unc_hi)
    );

    // Code of the stored word as it would be rewritten; only the address part is used here.
    ecc_ram_enc #(.ADDR_W(ADDR_W)) u_enc_cur (
        .word (fixed_word),
        .addr (addr),
        .code (cur_code)
    );

    assign addr_bad = (raw_chk.acode != cur_code.acode);

    // ---------------------------------------------------------------- write path
    for (genvar k = 0; k < BYTES; k++) begin : g_merge
        assign merged[k*8 +: 8] = be[k] ? wdata[k*8 +: 8] : fixed_word[k*8 +: 8];
    end

    ecc_ram_enc #(.ADDR_W(ADDR_W)) u_enc_wr (
        .word (merged),
        .addr (addr),
        .code (merged_code)
    );

    always_comb begin
        we_data  = 1'b0;
        we_chk   = 1'b0;
        st_wdata = merged;
        st_wchk  = merged_code;
        if (state_d == ST_WRITE) begin
            unique case (mode_v)
                MODE_NORMAL: begin
                    we_data = 1'b1;
                    we_chk  = 1'b1;
                end
                MODE_DTEST: begin
                    we_data  = 1'b1;
                    st_wdata = wdata;
                end
                MODE_CTEST: begin
                    we_chk  = 1'b1;
                    st_wchk = chk_unpack(wdata);
                end
                MODE_RSVD: begin
                    we_data = 1'b0;
                end
            endcase
        end
    end

    // ---------------------------------------------------------------- next state
    always_comb begin
        state_d = ST_IDLE;
        if (rd_en && wr_en) begin
            state_d = ST_REJECT;
        end else if (rd_en || wr_en) begin
            unique case (mode_v)
                MODE_NORMAL: state_d = wr_en ? ST_WRITE : ST_NREAD;
                MODE_DTEST:  state_d = !full_be ? ST_REJECT
                                     : (wr_en ? ST_WRITE : ST_DREAD);
                MODE_CTEST:  state_d = !full_be ? ST_REJECT
                                     : (wr_en ? ST_WRITE : ST_CREAD);
                MODE_RSVD:   state_d = ST_REJECT;
            endcase
        end
    end

    // ---------------------------------------------------------------- state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------------------------------------------------------- output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            corr_q  <= 1'b0;
            unc_q   <= 1'b0;
            aerr_q  <= 1'b0;
            acc_q   <= 1'b0;
        end else begin
            corr_q <= 1'b0;
            unc_q  <= 1'b0;
            aerr_q <= 1'b0;
            acc_q  <= 1'b0;
            unique case (state_d)
                ST_NREAD: begin
                    rdata_q <= fixed_word;
                    corr_q  <= corr_lo | corr_hi;
                    unc_q   <= unc_lo | unc_hi | addr_bad;
                    aerr_q  <= addr_bad;
                end
                ST_DREAD:  rdata_q <= raw_word;
                ST_CREAD:  rdata_q <= chk_pack(raw_chk);
                ST_REJECT: acc_q   <= 1'b1;
                ST_IDLE, ST_WRITE: acc_q <= 1'b0;
                default:   acc_q   <= 1'b0;
            endcase
        end
    end

    assign rdata      = rdata_q;
    assign rvalid     = (state_q == ST_NREAD) || (state_q == ST_DREAD) || (state_q == ST_CREAD);
    assign err_corr   = corr_q;
    assign err_uncorr = unc_q;
    assign err_addr   = aerr_q;
    assign acc_err    = acc_q;

endmodule

// File: rtl/ecc_ram_chk.sv
`timescale 1ns/1ps
module ecc_ram_chk #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [1:0]        mode,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        be,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              rvalid,
    input logic              err_corr,
    input logic              err_uncorr,
    input logic              err_addr,
    input logic              acc_err
);
    logic legal_rd;
    assign legal_rd = rd_en && !wr_en &&
                      ((mode == 2'b00) || ((mode != 2'b11) && (be == 4'hF)));

    p_rd_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        legal_rd |=> rvalid);

    p_write_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> (!rvalid && !err_corr && !err_uncorr && !err_addr));

    p_flags_normal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_corr || err_uncorr || err_addr) |-> (rvalid && $past(mode) == 2'b00));

    p_addr_uncorr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr |-> err_uncorr);

    p_test_partial_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && mode != 2'b00 && be != 4'hF) |=> (acc_err && !rvalid));

    p_both_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> (acc_err && !rvalid));

    p_rsvd_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && mode == 2'b11) |=> acc_err);

    p_reset_quiet_r11: assert property (@(posedge clk)
        !rst_n |-> (!rvalid && !acc_err && !err_corr && !err_uncorr && !err_addr));

endmodule

bind ecc_ram ecc_ram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .mode       (mode),
    .addr       (addr),
    .be         (be),
    .wdata      (wdata),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .err_corr   (err_corr),
    .err_uncorr (err_uncorr),
    .err_addr   (err_addr),
    .acc_err    (acc_err)
);

// File: tb/ecc_ram_tb.sv
`timescale 1ns/1ps
module ecc_ram_tb;
    import ecc_ram_pkg::*;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [3:0]    be = 4'h0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          rvalid, err_corr, err_uncorr, err_addr, acc_err;

    always #2.5 clk = ~clk;

    ecc_ram #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .mode(mode),
        .addr(addr), .be(be), .wdata(wdata), .rdata(rdata), .rvalid(rvalid),
        .err_corr(err_corr), .err_uncorr(err_uncorr), .err_addr(err_addr),
        .acc_err(acc_err)
    );

    typedef struct {
        bit          vld;
        logic [31:0] d;
        bit          c, u, a, x;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    function automatic exp_t ex(bit v, logic [31:0] d, bit c, bit u, bit a, bit x, string t);
        exp_t e;
        e.vld = v; e.d = d; e.c = c; e.u = u; e.a = a; e.x = x; e.tag = t;
        return e;
    endfunction

    function automatic logic [31:0] fmt(logic [AW-1:0] a, logic [31:0] d);
        return {9'b0, hsiao_enc(16'(a)), 1'b0, hsiao_enc(d[31:16]), 1'b0, hsiao_enc(d[15:0])};
    endfunction

    task automatic drive(bit r, bit w, logic [1:0] m, logic [AW-1:0] a,
                         logic [3:0] b, logic [31:0] wd, exp_t e);
        @(negedge clk);
        rd_en = r; wr_en = w; mode = m; addr = a; be = b; wdata = wd;
        q.push_back(e);
    endtask

    task automatic wr(logic [1:0] m, logic [AW-1:0] a, logic [3:0] b, logic [31:0] d, string t);
        drive(0, 1, m, a, b, d, ex(0, '0, 0, 0, 0, 0, t));
    endtask

    task automatic rd(logic [1:0] m, logic [AW-1:0] a, logic [3:0] b, exp_t e);
        drive(1, 0, m, a, b, 32'h0, e);
    endtask

    task automatic idle();
        drive(0, 0, 2'b00, '0, 4'h0, 32'h0, ex(0, '0, 0, 0, 0, 0, "idle"));
    endtask

    // Monitor: one expected item per driven cycle, compared after the capturing edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rvalid !== e.vld || err_corr !== e.c || err_uncorr !== e.u ||
                    err_addr !== e.a || acc_err !== e.x || (e.vld && rdata !== e.d)) begin
                    errors++;
                    $display("FAIL %s: got v=%0b d=%h c=%0b u=%0b a=%0b x=%0b exp v=%0b d=%h c=%0b u=%0b a=%0b x=%0b",
                             e.tag, rvalid, rdata, err_corr, err_uncorr, err_addr, acc_err,
                             e.vld, e.d, e.c, e.u, e.a, e.x);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        checks++;
        if (rvalid || err_corr || err_uncorr || err_addr || acc_err) begin
            errors++;
            $display("FAIL R11 in reset: got %0b%0b%0b%0b%0b exp 00000",
                     rvalid, err_corr, err_uncorr, err_addr, acc_err);
        end
        rst_n = 1'b1;
        idle();

        // R1 basic write/read, partial read enables
        wr(2'b00, 6'd5, 4'hF, 32'hDEAD_BEEF, "R1 wr");
        rd(2'b00, 6'd5, 4'hF, ex(1, 32'hDEAD_BEEF, 0, 0, 0, 0, "R1 rd"));
        wr(2'b00, 6'd42, 4'hF, 32'h1234_5678, "R1 wr2");
        rd(2'b00, 6'd42, 4'h2, ex(1, 32'h1234_5678, 0, 0, 0, 0, "R1 partial rd"));

        // R6 check layout
        rd(2'b10, 6'd5, 4'hF, ex(1, fmt(6'd5, 32'hDEAD_BEEF), 0, 0, 0, 0, "R6 ctest rd"));

        // R2 data-bit faults in each half
        wr(2'b01, 6'd5, 4'hF, 32'hDEAD_BEEF ^ 32'h8, "R2 inject lo");
        rd(2'b00, 6'd5, 4'hF, ex(1, 32'hDEAD_BEEF, 1, 0, 0, 0, "R2 fix lo"));
        wr(2'b01, 6'd5, 4'hF, 32'hDEAD_BEEF ^ 32'h0010_0000, "R2 inject hi");
        rd(2'b00, 6'd5, 4'hF, ex(1, 32'hDEAD_BEEF, 1, 0, 0, 0, "R2 fix hi"));

        // R2 check-bit fault
        d = 32'hA5A5_0F0F;
        wr(2'b00, 6'd7, 4'hF, d, "R2 wr");
        wr(2'b10, 6'd7, 4'hF, fmt(6'd7, d) ^ 32'h200, "R2 inject chk");
        rd(2'b00, 6'd7, 4'hF, ex(1, d, 1, 0, 0, 0, "R2 chk bit"));

        // R3 double fault
        wr(2'b00, 6'd8, 4'hF, d, "R3 wr");
        wr(2'b01, 6'd8, 4'hF, d ^ 32'h3, "R3 inject");
        rd(2'b00, 6'd8, 4'hF, ex(1, d ^ 32'h3, 0, 1, 0, 0, "R3 double"));

        // R4 address code fault
        wr(2'b00, 6'd9, 4'hF, d, "R4 wr");
        wr(2'b10, 6'd9, 4'hF, fmt(6'd9, d) ^ 32'h0004_0000, "R4 inject");
        rd(2'b00, 6'd9, 4'hF, ex(1, d, 0, 1, 1, 0, "R4 addr"));

        // Same-cycle correction and double fault (R2 and R3)
        wr(2'b00, 6'd10, 4'hF, d, "R2R3 wr");
        wr(2'b01, 6'd10, 4'hF, d ^ 32'h4 ^ 32'h0300_0000, "R2R3 inject");
        rd(2'b00, 6'd10, 4'hF, ex(1, d ^ 32'h0300_0000, 1, 1, 0, 0, "R2R3 both"));

        // R5 raw read, codes untouched
        rd(2'b01, 6'd10, 4'hF, ex(1, d ^ 32'h4 ^ 32'h0300_0000, 0, 0, 0, 0, "R5 raw rd"));
        rd(2'b10, 6'd10, 4'hF, ex(1, fmt(6'd10, d), 0, 0, 0, 0, "R5 codes kept"));

        // R7 unused bits ignored, data kept
        wr(2'b00, 6'd11, 4'hF, d, "R7 wr");
        wr(2'b10, 6'd11, 4'hF, fmt(6'd11, d) | 32'hFF80_8080, "R7 ctest wr");
        rd(2'b10, 6'd11, 4'hF, ex(1, fmt(6'd11, d), 0, 0, 0, 0, "R7 ctest rd"));
        rd(2'b00, 6'd11, 4'hF, ex(1, d, 0, 0, 0, 0, "R7 data kept"));

        // R8 partial access in test modes
        wr(2'b00, 6'd12, 4'hF, d, "R8 wr");
        drive(0, 1, 2'b10, 6'd12, 4'h7, 32'h007F_7F7F, ex(0, '0, 0, 0, 0, 1, "R8 ctest wr rej"));
        drive(0, 1, 2'b01, 6'd12, 4'hE, 32'hFFFF_FFFF, ex(0, '0, 0, 0, 0, 1, "R8 dtest wr rej"));
        rd(2'b01, 6'd12, 4'h1, ex(0, '0, 0, 0, 0, 1, "R8 dtest rd rej"));
        rd(2'b10, 6'd12, 4'hF, ex(1, fmt(6'd12, d), 0, 0, 0, 0, "R8 codes kept"));
        rd(2'b00, 6'd12, 4'hF, ex(1, d, 0, 0, 0, 0, "R8 data kept"));

        // R9 reserved mode and both strobes
        drive(0, 1, 2'b11, 6'd12, 4'hF, 32'h0, ex(0, '0, 0, 0, 0, 1, "R9 rsvd wr"));
        rd(2'b11, 6'd12, 4'hF, ex(0, '0, 0, 0, 0, 1, "R9 rsvd rd"));
        drive(1, 1, 2'b00, 6'd12, 4'hF, 32'h0, ex(0, '0, 0, 0, 0, 1, "R9 both strobes"));
        rd(2'b00, 6'd12, 4'hF, ex(1, d, 0, 0, 0, 0, "R9 data kept"));

        // R10 read-modify-write, plain and with a planted fault
        wr(2'b00, 6'd13, 4'hF, 32'h1122_3344, "R10 wr");
        wr(2'b00, 6'd13, 4'h5, 32'hAABB_CCDD, "R10 partial");
        rd(2'b00, 6'd13, 4'hF, ex(1, 32'h11BB_33DD, 0, 0, 0, 0, "R10 merged"));
        wr(2'b01, 6'd13, 4'hF, 32'h11BB_33DD ^ 32'h4000_0000, "R10 inject");
        wr(2'b00, 6'd13, 4'h1, 32'h0000_00EE, "R10 partial fix");
        rd(2'b00, 6'd13, 4'hF, ex(1, 32'h11BB_33EE, 0, 0, 0, 0, "R10 repaired"));

        idle();
        idle();
        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule